// File: doc/BRIEF.md
# Converter Conversion-Request Sequencer

This block sequences conversions for a multi-channel sample converter through a small register interface. Software writes one control word. The word enables the converter and chooses a per-channel or multi-channel pattern, a channel bank and a channel number. A start flag in the same word launches the sequence. The sequencer then asks an external sample provider for four samples, one at a time, and stores each sample. When the fourth sample is stored it raises a done event on the line that feeds bit 0 of interrupt status bank 0.

Software then reads the four results one after another from the result register. A pointer steps through the samples on each read and returns to the first sample after the fourth. The start flag clears itself when the sequence begins, so software never has to clear it. A start can wait for an external trigger, or the trigger can be bypassed. The analog converter, its biasing and its reference sit behind the sample-provider handshake and are not part of this block.

Top module: `adcseq_top`

## Requirements
- R1: After reset, every control bit reads 0, no sample request is raised, the done event is low and the read data is 0.
- R2: A write to address 44 stores the whole 24-bit word, except bit 20. A read of address 44 returns the stored word with bit 20 showing the pending start. A read answers on the edge that samples the read strobe. The functional fields are: bit 0 enable, bit 1 single-channel mode, bit 3 upper bank (channels 8 to 15), bits 7:5 channel number, bit 21 trigger bypass. Bits 10:8 hold a second channel field that is stored and read back only.
- R3: With enable and trigger bypass both set, a written start begins the sequence on the next edge. The start flag then reads back as 0.
- R4: With trigger bypass clear, a pending start waits until `ext_trig` is high at a clock edge.
- R5: A start flag written while a sequence is busy is discarded. It never causes a second sequence. A start written while enable is 0 stays pending and raises no request.
- R6: In single-channel mode, all four requests carry channel {bank bit, bits 7:5}.
- R7: In multi-channel mode, the requests carry channels bank*8+0, +1, +2 and +3, in that order.
- R8: The sequencer holds `smp_req` and `smp_chan` unchanged until `smp_valid` is high at an edge. Each such edge captures exactly one sample.
- R9: `irq_adc_done` is high for exactly one cycle, the cycle after the fourth capture. `smp_req` falls in that same cycle.
- R10: Each read of address 45 returns the next stored sample in capture order, zero-extended to 24 bits. After the fourth read the next read returns the first sample again. Writes to address 45 have no effect.
- R11: The start of a new sequence resets the result pointer to the first sample.
- R12: A read of any address other than 44 or 45 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Registered read data |
| ext_trig | input | 1 | External conversion trigger |
| smp_req | output | 1 | Sample request to the provider |
| smp_chan | output | 4 | Channel of the requested sample |
| smp_valid | input | 1 | Provider returns a sample this cycle |
| smp_data | input | 10 | Sample value |
| irq_adc_done | output | 1 | Conversion-done event, status bank 0 bit 0 |

## Verification
Some properties are checked on every cycle:
- the request and its channel stay steady while no sample comes back;
- the done event lasts one cycle and always follows a capture;
- a started sequence leaves no start pending;
- the read pointer restarts when a sequence begins.

Other behaviours only show up in the bench's scenarios:
- the channel order in each mode;
- the wait for the trigger, and how a disabled converter holds a start;
- a start discarded during a busy sequence;
- the values read back through the wrapping pointer.

The bench covers these against its behavioural model, cycle by cycle.

// File: rtl/adcseq_pkg.sv
// Shared constants of the conversion sequencer: control field positions
// and the channel width. Assumes a 24-bit register data path.
package adcseq_pkg;
    localparam int CTL_EN     = 0;
    localparam int CTL_SINGLE = 1;
    localparam int CTL_BANK   = 3;
    localparam int CTL_CHN    = 5;
    localparam int CHN_W      = 3;
    localparam int CTL_START  = 20;
    localparam int CTL_BYPASS = 21;
    localparam int CH_W       = CHN_W + 1;

    typedef struct packed {
        logic             single;
        logic             bank;
        logic [CHN_W-1:0] chn;
    } seq_cfg_t;
endpackage

// File: rtl/adcseq_ctrl.sv
// Control register and start arbitration. Stores the written word, keeps the
// start flag as a pending bit, and issues a one-cycle begin when enable is set,
// the trigger condition holds and the engine is idle.
// Assumes DATA_W is wider than the highest control bit.
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 24,
    parameter int CTRL_ADDR = 44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_trig,
    input  logic              busy,
    output logic [DATA_W-1:0] ctl_word,
    output seq_cfg_t          cfg,
    output logic              begin_seq
);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTRL_ADDR);

    logic [DATA_W-1:0] ctl_q;
    logic              start_pend;
    logic              wr_hit;

    assign wr_hit = wr_en && (addr == A_CTL);

    // Store the control word; the start position is kept apart as pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_hit) begin
            ctl_q             <= wdata;
            ctl_q[CTL_START]  <= 1'b0;
        end
    end

    // Pending start: cleared by begin, loaded by a write only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
        end else if (begin_seq) begin
            start_pend <= 1'b0;
        end else if (wr_hit && !busy) begin
            start_pend <= wdata[CTL_START];
        end
    end

    // Begin condition: armed, enabled, triggered or bypassed, engine idle.
    always_comb begin
        begin_seq = start_pend && ctl_q[CTL_EN] && !busy &&
                    (ctl_q[CTL_BYPASS] || ext_trig);
    end

    // Readback word and the configuration seen by the engine.
    always_comb begin
        ctl_word            = ctl_q;
        ctl_word[CTL_START] = start_pend;
        cfg.single          = ctl_q[CTL_SINGLE];
        cfg.bank            = ctl_q[CTL_BANK];
        cfg.chn             = ctl_q[CTL_CHN +: CHN_W];
    end

    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        begin_seq |=> !start_pend);
    p_busy_no_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_pend);
endmodule

// File: rtl/adcseq_engine.sv
// Sequence engine. On begin it latches the configuration and requests
// NUM_SMP samples one by one, holding each request until the provider answers.
// After the last capture it pulses the done event for one cycle.
// Assumes NUM_SMP is between 2 and 8 so a channel stays inside its bank.
module adcseq_engine
    import adcseq_pkg::*;
#(
    parameter int NUM_SMP = 4,
    parameter int SMP_W   = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      begin_seq,
    input  seq_cfg_t                  cfg,
    input  logic                      smp_valid,
    input  logic [SMP_W-1:0]          smp_data,
    output logic                      smp_req,
    output logic [CH_W-1:0]           smp_chan,
    output logic                      cap_we,
    output logic [$clog2(NUM_SMP)-1:0] cap_idx,
    output logic [SMP_W-1:0]          cap_data,
    output logic                      busy,
    output logic                      done_evt
);
    localparam int IDX_W = $clog2(NUM_SMP);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SMP - 1);

    typedef enum logic {S_IDLE, S_RUN} state_t;

    state_t            state_q;
    logic [IDX_W-1:0]  idx_q;
    seq_cfg_t          cfg_q;
    logic              take;

    assign take = (state_q == S_RUN) && smp_valid;

    // State and sample index progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else if (begin_seq) begin
            state_q <= S_RUN;
            idx_q   <= '0;
        end else if (take) begin
            if (idx_q == LAST) begin
                state_q <= S_IDLE;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Configuration snapshot, so later register writes do not disturb a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (begin_seq) begin
            cfg_q <= cfg;
        end
    end

    // One-cycle done event after the final capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_evt <= 1'b0;
        end else begin
            done_evt <= take && (idx_q == LAST);
        end
    end

    // Channel selection: fixed channel or bank base plus index.
    always_comb begin
        if (cfg_q.single) begin
            smp_chan = {cfg_q.bank, cfg_q.chn};
        end else begin
            smp_chan = {cfg_q.bank, CHN_W'(idx_q)};
        end
    end

    assign smp_req  = (state_q == S_RUN);
    assign busy     = (state_q == S_RUN);
    assign cap_we   = take;
    assign cap_idx  = idx_q;
    assign cap_data = smp_data;

    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && !smp_valid) |=> (smp_req && $stable(smp_chan)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !done_evt);
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> ($past(smp_req && smp_valid) && !smp_req));
endmodule

// File: rtl/adcseq_resbuf.sv
// Result storage: NUM_SMP entries written by index, read through a pointer
// that steps on every result read, wraps, and restarts on a new sequence.
module adcseq_resbuf #(
    parameter int NUM_SMP = 4,
    parameter int SMP_W   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap_we,
    input  logic [$clog2(NUM_SMP)-1:0] cap_idx,
    input  logic [SMP_W-1:0]           cap_data,
    input  logic                       begin_seq,
    input  logic                       rd_adv,
    output logic [SMP_W-1:0]           cur
);
    localparam int IDX_W = $clog2(NUM_SMP);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SMP - 1);

    logic [SMP_W-1:0] mem_q [NUM_SMP];
    logic [IDX_W-1:0] ptr_q;

    // Sample storage, one entry per capture index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SMP; i++) mem_q[i] <= '0;
        end else if (cap_we) begin
            mem_q[cap_idx] <= cap_data;
        end
    end

    // Read pointer: restart wins over advance; wraps after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (begin_seq) begin
            ptr_q <= '0;
        end else if (rd_adv) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign cur = mem_q[ptr_q];

    p_ptr_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        begin_seq |=> (ptr_q == '0));
endmodule

// File: rtl/adcseq_top.sv
// Conversion-request sequencer top: control register, sequence engine and
// result buffer, with a registered read-data port.
// Assumes single-cycle read and write strobes.
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 24,
    parameter int SMP_W     = 10,
    parameter int NUM_SMP   = 4,
    parameter int CTRL_ADDR = 44,
    parameter int RES_ADDR  = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_trig,
    output logic              smp_req,
    output logic [CH_W-1:0]   smp_chan,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              irq_adc_done
);
    localparam int IDX_W = $clog2(NUM_SMP);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_RES = ADDR_W'(RES_ADDR);

    logic [DATA_W-1:0] ctl_word;
    seq_cfg_t          cfg;
    logic              begin_seq;
    logic              busy;
    logic              cap_we;
    logic [IDX_W-1:0]  cap_idx;
    logic [SMP_W-1:0]  cap_data;
    logic [SMP_W-1:0]  cur;
    logic              rd_adv;

    adcseq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .ext_trig(ext_trig), .busy(busy),
        .ctl_word(ctl_word), .cfg(cfg), .begin_seq(begin_seq)
    );

    adcseq_engine #(.NUM_SMP(NUM_SMP), .SMP_W(SMP_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .begin_seq(begin_seq), .cfg(cfg),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_req(smp_req),
        .smp_chan(smp_chan), .cap_we(cap_we), .cap_idx(cap_idx),
        .cap_data(cap_data), .busy(busy), .done_evt(irq_adc_done)
    );

    adcseq_resbuf #(.NUM_SMP(NUM_SMP), .SMP_W(SMP_W)) u_resbuf (
        .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .cap_idx(cap_idx),
        .cap_data(cap_data), .begin_seq(begin_seq), .rd_adv(rd_adv), .cur(cur)
    );

    assign rd_adv = reg_rd && (reg_addr == A_RES);

    // Registered read mux: control word, current result, or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (reg_addr == A_CTL) begin
                reg_rdata <= ctl_word;
            end else if (reg_addr == A_RES) begin
                reg_rdata <= DATA_W'(cur);
            end else begin
                reg_rdata <= '0;
            end
        end
    end

    p_req_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_adc_done |-> !smp_req);
endmodule

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;
    localparam int EN = 1, SGL = 2, BANK = 8, START = 1 << 20, BYP = 1 << 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        ext_trig = 1'b0;
    logic        smp_req;
    logic [3:0]  smp_chan;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_data = '0;
    logic        irq_adc_done;

    int total = 0, bad = 0;
    int cyc = 0;
    int done_cnt = 0;
    int req_cycles = 0;
    int src_lat = 0, src_cnt = 0, served = 0;
    int chan_q[$];
    int data_q[$];
    bit cmp_on = 0;

    // behavioural model state
    int m_ctl = 0, m_pend = 0, m_busy = 0, m_idx = 0, m_done = 0, m_ptr = 0, m_rdata = 0;
    int m_sgl = 0, m_bank = 0, m_chn = 0;
    int m_buf[4] = '{0, 0, 0, 0};

    always #2.5 clk = ~clk;

    adcseq_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_trig(ext_trig), .smp_req(smp_req), .smp_chan(smp_chan),
        .smp_valid(smp_valid), .smp_data(smp_data), .irq_adc_done(irq_adc_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Model: next state from the inputs present before each edge.
    always @(posedge clk) begin
        int beg, cap, busy0;
        if (!rst_n) begin
            m_ctl = 0; m_pend = 0; m_busy = 0; m_idx = 0; m_done = 0;
            m_ptr = 0; m_rdata = 0; m_sgl = 0; m_bank = 0; m_chn = 0;
            foreach (m_buf[i]) m_buf[i] = 0;
        end else begin
            busy0 = m_busy;
            beg = (m_pend && (m_ctl & EN) && !busy0 && ((m_ctl & BYP) || ext_trig)) ? 1 : 0;
            cap = (busy0 && smp_valid) ? 1 : 0;
            if (reg_rd) begin
                if (reg_addr == 44) m_rdata = m_ctl | (m_pend << 20);
                else if (reg_addr == 45) m_rdata = m_buf[m_ptr];
                else m_rdata = 0;
            end
            if (beg) m_ptr = 0;
            else if (reg_rd && reg_addr == 45) m_ptr = (m_ptr + 1) % 4;
            m_done = (cap && m_idx == 3) ? 1 : 0;
            if (cap) begin
                m_buf[m_idx] = int'(smp_data);
                if (m_idx == 3) m_busy = 0; else m_idx++;
            end
            if (beg) begin
                m_busy = 1; m_idx = 0;
                m_sgl = (m_ctl >> 1) & 1; m_bank = (m_ctl >> 3) & 1; m_chn = (m_ctl >> 5) & 7;
            end
            if (beg) m_pend = 0;
            else if (reg_wr && reg_addr == 44 && !busy0) m_pend = (int'(reg_wdata) >> 20) & 1;
            if (reg_wr && reg_addr == 44) m_ctl = int'(reg_wdata) & ~START;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R8 request level", int'(smp_req), m_busy);
            if (m_busy != 0)
                chk("R6/R7 request channel", int'(smp_chan),
                    m_sgl ? (m_bank * 8 + m_chn) : (m_bank * 8 + m_idx));
            chk("R9 done event", int'(irq_adc_done), m_done);
            chk("R2/R10 read data", int'(reg_rdata), m_rdata);
        end
        if (irq_adc_done) done_cnt++;
        if (smp_req) req_cycles++;
    end

    // Sample provider stub with a programmable answer delay.
    always @(negedge clk) begin
        if (smp_valid) begin
            smp_valid <= 1'b0;
            src_cnt = 0;
        end else if (smp_req && rst_n) begin
            if (src_cnt >= src_lat) begin
                smp_valid <= 1'b1;
                smp_data  <= {smp_chan, 6'(served)};
                chan_q.push_back(int'(smp_chan));
                data_q.push_back(int'({smp_chan, 6'(served)}));
                served++;
            end else begin
                src_cnt++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = 24'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 6'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        int start_cnt;
        int t;
        start_cnt = done_cnt;
        t = 0;
        while (done_cnt == start_cnt && t < 1000) begin
            @(negedge clk);
            t++;
        end
        chk("R9 done reached", (done_cnt > start_cnt) ? 1 : 0, 1);
        idle(2);
    endtask

    initial begin
        int v, d0;
        int exp_d[4];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        cmp_on = 1;
        // R1: reset state
        chk("R1 rdata", int'(reg_rdata), 0);
        chk("R1 req", int'(smp_req), 0);
        chk("R1 done", int'(irq_adc_done), 0);
        rd(44, v); chk("R1 control reads zero", v, 0);

        // R6, R3, R10: single channel 5, bank 0, bypass
        src_lat = 0;
        wr(44, EN | SGL | (5 << 5) | BYP | START);
        wait_done();
        for (int i = 0; i < 4; i++) begin
            chk("R6 single channel", chan_q.pop_front(), 5);
            exp_d[i] = data_q.pop_front();
        end
        for (int i = 0; i < 4; i++) begin
            rd(45, v); chk("R10 result order", v, exp_d[i]);
        end
        rd(45, v); chk("R10 pointer wraps", v, exp_d[0]);
        rd(44, v); chk("R3 start auto-clear and R2 readback", v, EN | SGL | (5 << 5) | BYP);

        // R7, R8, R5: multi channel upper bank, slow provider, start during busy
        src_lat = 3;
        wr(44, EN | BANK | (6 << 8) | BYP | START);
        idle(3);
        chk("R8 busy during slow provider", int'(smp_req), 1);
        wr(44, EN | BANK | (6 << 8) | BYP | START);
        wait_done();
        for (int i = 0; i < 4; i++) begin
            chk("R7 consecutive channels", chan_q.pop_front(), 8 + i);
            exp_d[i] = data_q.pop_front();
        end
        d0 = done_cnt;
        idle(20);
        chk("R5 start in busy discarded", done_cnt, d0);
        chk("R5 no extra requests", chan_q.size(), 0);
        rd(44, v); chk("R2 second field readback", v, EN | BANK | (6 << 8) | BYP);

        // R11: pointer restarts on a new sequence
        rd(45, v); chk("R10 first multi sample", v, exp_d[0]);
        src_lat = 1;
        wr(44, EN | SGL | BANK | (2 << 5) | BYP | START);
        wait_done();
        for (int i = 0; i < 4; i++) begin
            chk("R6 single upper bank channel", chan_q.pop_front(), 10);
            exp_d[i] = data_q.pop_front();
        end
        rd(45, v); chk("R11 pointer back at first", v, exp_d[0]);

        // R4: trigger needed when bypass is clear
        src_lat = 0;
        req_cycles = 0;
        wr(44, EN | START);
        idle(10);
        chk("R4 waits for trigger", req_cycles, 0);
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        wait_done();
        for (int i = 0; i < 4; i++) begin
            chk("R4 triggered run channels", chan_q.pop_front(), i);
            exp_d[i] = data_q.pop_front();
        end

        // R5: disabled converter keeps start pending
        req_cycles = 0;
        wr(44, BYP | START);
        idle(10);
        chk("R5 disabled no request", req_cycles, 0);
        rd(44, v); chk("R5 start still pending", v, BYP | START);

        // R10: write to result address ignored; R12: other address reads zero
        wr(45, 24'h3ff);
        rd(45, v); chk("R10 write to results ignored", v, exp_d[0]);
        rd(7, v); chk("R12 unmapped read", v, 0);
        rd(44, v); chk("R10 write left control intact", v, BYP | START);

        idle(4);
        finish_run();
    end
endmodule